// File: doc/BRIEF.md
# Serial Link Training Sequencer

This controller brings up one serial link lane group. A `start` pulse begins an attempt. The attempt resets the link layer and loads its configuration fields. It then asks an outside agent to reset the remote card, drives a preliminary pattern for a fixed number of milliseconds and hands lane tuning to a separate helper through a pulse/done pair. After that it starts training and polls the link's 3-bit state-machine status once per millisecond until the link reports trained or the timeout runs out.

A failed attempt starts again from the link-layer reset, up to a bounded number of attempts. A failed attempt is a timeout or a refused remote reset. When training succeeds the block raises transmit send-enable, pulses a credit-counter read strobe, latches the number of milliseconds training took and decodes the trained lane width. When the last attempt fails it holds an error flag instead. All time is counted in ticks of the `ms_tick` strobe, so the block does not depend on the system clock frequency.

The configuration fields are decoded from the sequencer state and go straight out to the link layer's configuration word. A `start` pulse at any point throws away the current progress and begins a fresh first attempt.

Top module: `link_train_seq`

## Requirements
- R1: After reset and until `start` is seen, every output is 0, including all configuration fields and the request, enable, flag, count and attempt outputs.
- R2: Each attempt begins with exactly one cycle of `cfg_reset`=1 and then one cycle of `cfg_reset`=0. In both cycles `cfg_version`=6'b000001, `cfg_train_mode`=4'b0110, `cfg_modes`=4'b0010, `cfg_phy_limit`=4'b1111 and `cfg_fwd_timer`=4'b0110.
- R3: After the reset-release cycle, `card_rst_req` rises with `cfg_reset`=0 and `cfg_train_mode` still 4'b0110. It stays high until `card_rst_ack` or `card_rst_nack` is seen. Ack continues the attempt, and ack wins if both are high. Nack makes the attempt a failed attempt.
- R4: After ack, `cfg_train_mode`=4'b0001 is held for exactly `PAT_MS` ticks. Then `bump_pulse` is high for one cycle, and the block waits for `bump_done`.
- R5: After `bump_done`, `cfg_train_mode`=4'b1000. `sm_status` is sampled on every tick. A value of 3'h7 is success, and `train_ms` is set to the number of ticks since training began, counting the success tick. `TIMEOUT_MS` ticks without success make the attempt a failed attempt.
- R6: `attempts` shows the number of the current attempt, starting at 1. A failed attempt restarts from R2 while `attempts` < `MAX_TRIES`. Otherwise `link_err` rises and stays high with `tx_send_en`=0 and `attempts`=`MAX_TRIES`.
- R7: On success `tx_send_en` rises and stays high. `credit_rd` is high for exactly the first cycle in which `tx_send_en` is high.
- R8: `trained_mode` is captured on the success tick. 4'b0001 sets `lane_x4`, 4'b0010 sets `lane_x8`, and any other code sets `hw_err`. Exactly one of the three is high while `tx_send_en` is high.
- R9: A `start` pulse in any state is followed, in the next cycle, by `cfg_reset`=1, `tx_send_en`=0, `link_err`=0, `attempts`=1, the width flags at 0 and `train_ms`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins (or restarts) the whole sequence |
| ms_tick | input | 1 | One-cycle strobe per millisecond |
| card_rst_ack | input | 1 | Remote card reset completed |
| card_rst_nack | input | 1 | Remote card reset refused |
| bump_done | input | 1 | Lane tuning helper finished |
| sm_status | input | 3 | Link training state-machine status |
| trained_mode | input | 4 | Link trained-width status code |
| cfg_reset | output | 1 | Link-layer reset bit of the configuration word |
| cfg_version | output | 6 | Version field |
| cfg_train_mode | output | 4 | Train-mode field |
| cfg_modes | output | 4 | Supported-modes field |
| cfg_phy_limit | output | 4 | PHY counter limit field |
| cfg_fwd_timer | output | 4 | Forward-progress timer field |
| card_rst_req | output | 1 | Request to reset the remote card |
| bump_pulse | output | 1 | Start lane tuning |
| tx_send_en | output | 1 | Transmit send-enable |
| credit_rd | output | 1 | Credit counter sample strobe |
| lane_x4 | output | 1 | Link trained at x4 |
| lane_x8 | output | 1 | Link trained at x8 |
| hw_err | output | 1 | Trained-width code not recognised |
| link_err | output | 1 | All attempts failed |
| train_ms | output | clog2(TIMEOUT_MS+1) | Milliseconds the successful training took |
| attempts | output | clog2(MAX_TRIES+1) | Number of the current attempt |

## Verification
Assertions check five rules on every cycle:
- the remote reset is never requested while the link-layer reset bit is set;
- transmit enable and the error flag never coincide;
- exactly one width flag accompanies transmit enable, with the credit strobe on its rising edge;
- `train_ms` stays within 1 to `TIMEOUT_MS`;
- the attempt count never exceeds its limit and equals it whenever the error flag is up.

Only the bench scenarios can show the ordering and durations of the phases: reset then release, request before pattern, a pattern lasting exactly `PAT_MS` ticks, and training only after the tuning handshake. They also cover the retry behaviour after timeouts and refused resets, success on the very first and very last polling tick, and a restart in the middle of training.

// File: rtl/lts_pkg.sv
package lts_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RST_ON,
        S_RST_OFF,
        S_CARD_REQ,
        S_PATTERN,
        S_BUMP_GO,
        S_BUMP_WAIT,
        S_TRAIN,
        S_RETRY,
        S_CREDIT,
        S_UP,
        S_FAILED
    } seq_state_e;

    typedef enum logic [1:0] {
        W_NONE,
        W_X4,
        W_X8,
        W_BAD
    } width_e;

    typedef struct packed {
        logic       reset;
        logic [5:0] version;
        logic [3:0] mode;
        logic [3:0] modes;
        logic [3:0] phy_limit;
        logic [3:0] fwd_timer;
    } link_cfg_t;

    localparam logic [5:0] CFG_VERSION   = 6'b000001;
    localparam logic [3:0] CFG_MODES     = 4'b0010;
    localparam logic [3:0] CFG_PHY_LIMIT = 4'b1111;
    localparam logic [3:0] CFG_FWD_TIMER = 4'b0110;
    localparam logic [3:0] MODE_RESET    = 4'b0110;
    localparam logic [3:0] MODE_PATTERN  = 4'b0001;
    localparam logic [3:0] MODE_TRAIN    = 4'b1000;
    localparam logic [2:0] SM_TRAINED    = 3'h7;
    localparam logic [3:0] TM_X4         = 4'b0001;
    localparam logic [3:0] TM_X8         = 4'b0010;

    // Configuration word implied by each sequencer state.
    function automatic link_cfg_t cfg_for(seq_state_e s);
        link_cfg_t c;
        c = '0;
        if (s != S_IDLE) begin
            c.version   = CFG_VERSION;
            c.modes     = CFG_MODES;
            c.phy_limit = CFG_PHY_LIMIT;
            c.fwd_timer = CFG_FWD_TIMER;
        end
        case (s)
            S_RST_ON: begin
                c.reset = 1'b1;
                c.mode  = MODE_RESET;
            end
            S_RST_OFF, S_CARD_REQ, S_RETRY:       c.mode = MODE_RESET;
            S_PATTERN, S_BUMP_GO, S_BUMP_WAIT:    c.mode = MODE_PATTERN;
            S_TRAIN, S_CREDIT, S_UP, S_FAILED:    c.mode = MODE_TRAIN;
            default: ;
        endcase
        return c;
    endfunction

    function automatic width_e decode_width(logic [3:0] code);
        case (code)
            TM_X4:   return W_X4;
            TM_X8:   return W_X8;
            default: return W_BAD;
        endcase
    endfunction

endpackage

// File: rtl/lts_ms_counter.sv
module lts_ms_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick,
    output logic [CNT_W-1:0] count
);

    // Saturating millisecond counter, cleared whenever the sequencer changes phase.
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (tick && (count != '1)) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/lts_sequencer.sv
module lts_sequencer
    import lts_pkg::*;
#(
    parameter int PAT_MS     = 5,
    parameter int TIMEOUT_MS = 3000,
    parameter int MAX_TRIES  = 20,
    parameter int CNT_W      = 12,
    parameter int MS_W       = 12,
    parameter int ATT_W      = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             ms_tick,
    input  logic             card_rst_ack,
    input  logic             card_rst_nack,
    input  logic             bump_done,
    input  logic [2:0]       sm_status,
    input  logic [3:0]       trained_mode,
    input  logic [CNT_W-1:0] cnt,
    output logic             cnt_clr,
    output link_cfg_t        cfg,
    output logic             card_rst_req,
    output logic             bump_pulse,
    output logic             tx_send_en,
    output logic             credit_rd,
    output logic             lane_x4,
    output logic             lane_x8,
    output logic             hw_err,
    output logic             link_err,
    output logic [MS_W-1:0]  train_ms,
    output logic [ATT_W-1:0] attempts
);

    seq_state_e state, nxt;
    width_e     width_q;

    logic trained_now;
    logic pat_done;
    logic timed_out;
    logic last_try;

    assign trained_now = (state == S_TRAIN) && ms_tick && (sm_status == SM_TRAINED);
    assign pat_done    = ms_tick && (cnt == CNT_W'(PAT_MS - 1));
    assign timed_out   = ms_tick && (cnt == CNT_W'(TIMEOUT_MS - 1));
    assign last_try    = (attempts >= ATT_W'(MAX_TRIES));

    always_comb begin
        nxt = state;
        if (start) begin
            nxt = S_RST_ON;
        end else begin
            case (state)
                S_IDLE:      nxt = S_IDLE;
                S_RST_ON:    nxt = S_RST_OFF;
                S_RST_OFF:   nxt = S_CARD_REQ;
                S_CARD_REQ: begin
                    if (card_rst_ack)       nxt = S_PATTERN;
                    else if (card_rst_nack) nxt = S_RETRY;
                end
                S_PATTERN:   if (pat_done) nxt = S_BUMP_GO;
                S_BUMP_GO:   nxt = S_BUMP_WAIT;
                S_BUMP_WAIT: if (bump_done) nxt = S_TRAIN;
                S_TRAIN: begin
                    if (trained_now)    nxt = S_CREDIT;
                    else if (timed_out) nxt = S_RETRY;
                end
                S_RETRY:     nxt = last_try ? S_FAILED : S_RST_ON;
                S_CREDIT:    nxt = S_UP;
                S_UP:        nxt = S_UP;
                S_FAILED:    nxt = S_FAILED;
                default:     nxt = S_IDLE;
            endcase
        end
    end

    assign cnt_clr = (nxt != state);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            attempts <= '0;
            train_ms <= '0;
            width_q  <= W_NONE;
        end else begin
            state <= nxt;
            if (start) begin
                attempts <= ATT_W'(1);
                train_ms <= '0;
                width_q  <= W_NONE;
            end else begin
                if (state == S_RETRY && !last_try) begin
                    attempts <= attempts + 1'b1;
                end
                if (trained_now) begin
                    train_ms <= MS_W'(cnt) + MS_W'(1);
                    width_q  <= decode_width(trained_mode);
                end
            end
        end
    end

    assign cfg          = cfg_for(state);
    assign card_rst_req = (state == S_CARD_REQ);
    assign bump_pulse   = (state == S_BUMP_GO);
    assign tx_send_en   = (state == S_CREDIT) || (state == S_UP);
    assign credit_rd    = (state == S_CREDIT);
    assign link_err     = (state == S_FAILED);
    assign lane_x4      = (width_q == W_X4);
    assign lane_x8      = (width_q == W_X8);
    assign hw_err       = (width_q == W_BAD);

    // R3: the remote card is never asked to reset while the link layer is held in reset
    p_req_after_release_r3: assert property (@(posedge clk) disable iff (rst)
        card_rst_req |-> !cfg.reset);

    // R5: a trained link reports a duration inside the polling window
    p_ms_in_window_r5: assert property (@(posedge clk) disable iff (rst)
        tx_send_en |-> (train_ms >= MS_W'(1)) && (train_ms <= MS_W'(TIMEOUT_MS)));

    // R6: success and final failure exclude each other
    p_up_err_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(tx_send_en && link_err));

    // R6: attempt count bounded, and at its limit when the link is errored
    p_attempt_bound_r6: assert property (@(posedge clk) disable iff (rst)
        attempts <= ATT_W'(MAX_TRIES));
    p_err_at_limit_r6: assert property (@(posedge clk) disable iff (rst)
        link_err |-> (attempts == ATT_W'(MAX_TRIES)));

    // R7: the credit strobe accompanies the rise of transmit enable
    p_credit_on_rise_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_send_en) |-> credit_rd);

    // R8: exactly one width outcome while transmitting
    p_one_width_r8: assert property (@(posedge clk) disable iff (rst)
        tx_send_en |-> ($countones({lane_x4, lane_x8, hw_err}) == 1));

endmodule

// File: rtl/link_train_seq.sv
module link_train_seq
    import lts_pkg::*;
#(
    parameter int  PAT_MS     = 5,
    parameter int  TIMEOUT_MS = 3000,
    parameter int  MAX_TRIES  = 20,
    localparam int MS_W       = $clog2(TIMEOUT_MS + 1),
    localparam int ATT_W      = $clog2(MAX_TRIES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             ms_tick,
    input  logic             card_rst_ack,
    input  logic             card_rst_nack,
    input  logic             bump_done,
    input  logic [2:0]       sm_status,
    input  logic [3:0]       trained_mode,
    output logic             cfg_reset,
    output logic [5:0]       cfg_version,
    output logic [3:0]       cfg_train_mode,
    output logic [3:0]       cfg_modes,
    output logic [3:0]       cfg_phy_limit,
    output logic [3:0]       cfg_fwd_timer,
    output logic             card_rst_req,
    output logic             bump_pulse,
    output logic             tx_send_en,
    output logic             credit_rd,
    output logic             lane_x4,
    output logic             lane_x8,
    output logic             hw_err,
    output logic             link_err,
    output logic [MS_W-1:0]  train_ms,
    output logic [ATT_W-1:0] attempts
);

    localparam int SPAN  = (PAT_MS > TIMEOUT_MS) ? PAT_MS : TIMEOUT_MS;
    localparam int CNT_W = $clog2(SPAN + 1);

    logic [CNT_W-1:0] cnt;
    logic             cnt_clr;
    link_cfg_t        cfg;

    lts_ms_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (cnt_clr),
        .tick  (ms_tick),
        .count (cnt)
    );

    lts_sequencer #(
        .PAT_MS     (PAT_MS),
        .TIMEOUT_MS (TIMEOUT_MS),
        .MAX_TRIES  (MAX_TRIES),
        .CNT_W      (CNT_W),
        .MS_W       (MS_W),
        .ATT_W      (ATT_W)
    ) u_seq (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .ms_tick       (ms_tick),
        .card_rst_ack  (card_rst_ack),
        .card_rst_nack (card_rst_nack),
        .bump_done     (bump_done),
        .sm_status     (sm_status),
        .trained_mode  (trained_mode),
        .cnt           (cnt),
        .cnt_clr       (cnt_clr),
        .cfg           (cfg),
        .card_rst_req  (card_rst_req),
        .bump_pulse    (bump_pulse),
        .tx_send_en    (tx_send_en),
        .credit_rd     (credit_rd),
        .lane_x4       (lane_x4),
        .lane_x8       (lane_x8),
        .hw_err        (hw_err),
        .link_err      (link_err),
        .train_ms      (train_ms),
        .attempts      (attempts)
    );

    assign cfg_reset      = cfg.reset;
    assign cfg_version    = cfg.version;
    assign cfg_train_mode = cfg.mode;
    assign cfg_modes      = cfg.modes;
    assign cfg_phy_limit  = cfg.phy_limit;
    assign cfg_fwd_timer  = cfg.fwd_timer;

endmodule

// File: tb/link_train_seq_test.sv
module link_train_seq_test;

    localparam int PAT  = 5;
    localparam int TMO  = 12;
    localparam int MAXT = 3;
    localparam int MS_W  = $clog2(TMO + 1);
    localparam int ATT_W = $clog2(MAXT + 1);

    typedef struct {
        bit ok;
        bit err;
        bit x4;
        bit x8;
        bit hw;
        int ms;
        int att;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic ms_tick = 1'b0;
    logic card_rst_ack = 1'b0;
    logic card_rst_nack = 1'b0;
    logic bump_done = 1'b0;
    logic [2:0] sm_status = 3'd0;
    logic [3:0] trained_mode = 4'd0;
    logic cfg_reset, card_rst_req, bump_pulse, tx_send_en, credit_rd;
    logic lane_x4, lane_x8, hw_err, link_err;
    logic [5:0] cfg_version;
    logic [3:0] cfg_train_mode, cfg_modes, cfg_phy_limit, cfg_fwd_timer;
    logic [MS_W-1:0]  train_ms;
    logic [ATT_W-1:0] attempts;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    exp_t exp_q[$];

    int  succ_at [0:3];
    bit  nack_at [0:3];
    bit  env_on = 0;

    // environment state
    int div = 0;
    bit prev_reset = 0, prev_req = 0, prev_tx = 0, prev_res = 0;
    bit seen_release = 0, bump_seen = 0, done_seen = 0, in_train = 0;
    int pat_ticks = 0, req_wait = 0, bwait = 0, tcount = 0;

    always #4 clk = ~clk;

    link_train_seq #(.PAT_MS(PAT), .TIMEOUT_MS(TMO), .MAX_TRIES(MAXT)) uut (
        .clk(clk), .rst(rst), .start(start), .ms_tick(ms_tick),
        .card_rst_ack(card_rst_ack), .card_rst_nack(card_rst_nack),
        .bump_done(bump_done), .sm_status(sm_status), .trained_mode(trained_mode),
        .cfg_reset(cfg_reset), .cfg_version(cfg_version), .cfg_train_mode(cfg_train_mode),
        .cfg_modes(cfg_modes), .cfg_phy_limit(cfg_phy_limit), .cfg_fwd_timer(cfg_fwd_timer),
        .card_rst_req(card_rst_req), .bump_pulse(bump_pulse), .tx_send_en(tx_send_en),
        .credit_rd(credit_rd), .lane_x4(lane_x4), .lane_x8(lane_x8), .hw_err(hw_err),
        .link_err(link_err), .train_ms(train_ms), .attempts(attempts)
    );

    task automatic check(input bit cond, input string req, input int act, input int expv);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    task automatic check_fields(input string req, input bit rbit);
        check(cfg_reset == rbit, req, int'(cfg_reset), int'(rbit));
        check(cfg_version == 6'b000001 && cfg_train_mode == 4'b0110 &&
              cfg_modes == 4'b0010 && cfg_phy_limit == 4'b1111 &&
              cfg_fwd_timer == 4'b0110, req,
              int'({cfg_version, cfg_train_mode, cfg_modes, cfg_phy_limit, cfg_fwd_timer}),
              int'({6'b000001, 4'b0110, 4'b0010, 4'b1111, 4'b0110}));
    endtask

    // Environment: tick source, remote agents, phase checks and result monitor.
    always @(negedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            finish_run();
        end
        div = (div + 1) % 4;
        ms_tick = (div == 0);
        if (env_on) begin
            // R2: reset cycle and release cycle
            if (cfg_reset && !prev_reset) begin
                check_fields("R2 reset cycle", 1'b1);
                seen_release = 0; bump_seen = 0; done_seen = 0; pat_ticks = 0;
            end
            if (!cfg_reset && prev_reset) begin
                check_fields("R2 release cycle", 1'b0);
                seen_release = 1;
            end
            // R3: remote reset agent
            card_rst_ack = 1'b0;
            card_rst_nack = 1'b0;
            if (card_rst_req) begin
                if (!prev_req) begin
                    check(!cfg_reset && seen_release && cfg_train_mode == 4'b0110,
                          "R3 request order", int'(cfg_train_mode), 6);
                    req_wait = 0;
                end
                req_wait++;
                if (req_wait == 3) begin
                    if (nack_at[int'(attempts)]) card_rst_nack = 1'b1;
                    else card_rst_ack = 1'b1;
                end
            end
            // R4: pattern duration in ticks
            if (cfg_train_mode == 4'b0001 && !bump_pulse && !bump_seen && ms_tick)
                pat_ticks++;
            bump_done = 1'b0;
            if (bwait > 0) begin
                bwait--;
                if (bwait == 0) begin
                    bump_done = 1'b1;
                    done_seen = 1;
                end
            end
            if (bump_pulse) begin
                check(pat_ticks == PAT && !bump_seen, "R4 pattern length", pat_ticks, PAT);
                bump_seen = 1;
                bwait = 3;
            end
            // R5: training phase model
            if (cfg_train_mode == 4'b1000 && !tx_send_en && !link_err) begin
                if (!in_train) begin
                    check(done_seen, "R5 train after bump done", int'(done_seen), 1);
                    in_train = 1;
                    tcount = 0;
                end
                if (ms_tick) tcount++;
                sm_status = (succ_at[int'(attempts)] != 0 &&
                             tcount >= succ_at[int'(attempts)]) ? 3'h7 : 3'h3;
            end else begin
                in_train = 0;
                tcount = 0;
                sm_status = 3'h0;
            end
            // R7: credit strobe only on the first enabled cycle
            if (tx_send_en && !prev_tx)
                check(credit_rd == 1'b1, "R7 credit on rise", int'(credit_rd), 1);
            else if (tx_send_en)
                check(credit_rd == 1'b0, "R7 credit single", int'(credit_rd), 0);
            // Monitor: compare outcome against scoreboard
            if ((tx_send_en || link_err) && !prev_res) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 unexpected result", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(tx_send_en == e.ok, "R7 tx_send_en", int'(tx_send_en), int'(e.ok));
                    check(link_err == e.err, "R6 link_err", int'(link_err), int'(e.err));
                    check({lane_x4, lane_x8, hw_err} == {e.x4, e.x8, e.hw}, "R8 width flags",
                          int'({lane_x4, lane_x8, hw_err}), int'({e.x4, e.x8, e.hw}));
                    check(int'(train_ms) == e.ms, "R5 train_ms", int'(train_ms), e.ms);
                    check(int'(attempts) == e.att, "R6 attempts", int'(attempts), e.att);
                end
            end
            prev_reset = cfg_reset;
            prev_req   = card_rst_req;
            prev_tx    = tx_send_en;
            prev_res   = tx_send_en || link_err;
        end
    end

    // Driver: predict the outcome of the scenario, then start the sequencer.
    task automatic push_expected();
        exp_t e;
        e = '{ok: 0, err: 1, x4: 0, x8: 0, hw: 0, ms: 0, att: MAXT};
        for (int k = 1; k <= MAXT; k++) begin
            if (!nack_at[k] && succ_at[k] >= 1 && succ_at[k] <= TMO) begin
                e.ok = 1; e.err = 0; e.ms = succ_at[k]; e.att = k;
                e.x4 = (trained_mode == 4'b0001);
                e.x8 = (trained_mode == 4'b0010);
                e.hw = !e.x4 && !e.x8;
                break;
            end
        end
        exp_q.push_back(e);
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R9: next cycle shows a fresh first attempt
        check(cfg_reset && !tx_send_en && !link_err && attempts == ATT_W'(1) &&
              !lane_x4 && !lane_x8 && !hw_err && train_ms == '0, "R9 restart",
              int'({cfg_reset, tx_send_en, link_err, attempts}), int'({1'b1, 1'b0, 1'b0, ATT_W'(1)}));
    endtask

    task automatic run_case(input int s1, input int s2, input int s3,
                            input bit n1, input bit n2, input bit n3, input logic [3:0] tm);
        succ_at[1] = s1; succ_at[2] = s2; succ_at[3] = s3;
        nack_at[1] = n1; nack_at[2] = n2; nack_at[3] = n3;
        trained_mode = tm;
        push_expected();
        pulse_start();
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (tx_send_en || link_err) break;
        end
        repeat (6) @(negedge clk);
        check(exp_q.size() == 0, "R6 result produced", exp_q.size(), 0);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            succ_at[i] = 0;
            nack_at[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (20) @(negedge clk);
        // R1: idle after reset, no start yet
        check({cfg_reset, cfg_version, cfg_train_mode, cfg_modes, cfg_phy_limit, cfg_fwd_timer} == '0,
              "R1 config idle", int'(cfg_train_mode), 0);
        check({card_rst_req, bump_pulse, tx_send_en, credit_rd, lane_x4, lane_x8, hw_err, link_err} == '0,
              "R1 flags idle", int'({tx_send_en, link_err}), 0);
        check(train_ms == '0 && attempts == '0, "R1 counts idle", int'(attempts), 0);
        env_on = 1;

        run_case(3, 0, 0, 0, 0, 0, 4'b0010);    // x8 on first attempt
        run_case(1, 0, 0, 0, 0, 0, 4'b0001);    // x4 on first tick
        run_case(0, TMO, 0, 0, 0, 0, 4'b0010);  // timeout, then success on last tick
        run_case(5, 2, 0, 1, 0, 0, 4'b0001);    // nack, then success
        run_case(0, 0, 0, 0, 0, 0, 4'b0010);    // all attempts time out
        run_case(TMO + 1, 0, 4, 0, 0, 1, 4'b0010); // timeout, timeout, nack
        run_case(2, 0, 0, 0, 0, 0, 4'b0101);    // unknown width code

        // Restart in the middle of training
        succ_at[1] = 0; succ_at[2] = 0; succ_at[3] = 0;
        nack_at[1] = 0; nack_at[2] = 0; nack_at[3] = 0;
        pulse_start();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (in_train && tcount >= 3) break;
        end
        check(in_train && !tx_send_en, "R9 mid-train reached", int'(in_train), 1);
        run_case(6, 0, 0, 0, 0, 0, 4'b0010);

        finish_run();
    end

endmodule